// File: doc/BRIEF.md
# Quadrature Encoder Position and Speed Unit

This block turns the two phase lines and the index line of an incremental shaft encoder into feedback for a motor control loop. It counts every edge on either phase line, which gives four counts per encoder line, and takes the direction from which line leads. From those counts it keeps a signed mechanical position and a separate electrical angle index. The index runs around one electrical cycle of a multi-pole-pair motor, 400 counts by default, and feeds the sine/cosine lookup of the reference-frame transform.

Once per mechanical-loop sample strobe the block produces a speed estimate. When the shaft moves quickly, the estimate is the change in position since the previous strobe. When the shaft moves slowly, a per-sample difference says little, so the block instead reports the measured interval between the last two counted edges and flags that it has done so. If no edge arrives for the full range of the interval timer, the slow-mode estimate is zero. Speed leaves the block on a valid/ready output. A result stays on the port until the consumer accepts it. If a newer result is ready before that, it replaces the pending one, so the consumer always sees the latest estimate and never a stale one.

The phase and index lines pass through synchroniser flops inside the block. A sample in which both phase lines change at once cannot be decoded. Such a jump produces no count and sets a sticky error flag.

Top module: `qenc_pos_speed`

## Requirements
- R1: With the phase pair written as {A,B}, the forward sequence is 00→10→11→01→00. Each forward transition adds one to the position and each reverse transition subtracts one. A count becomes visible three clock edges after the input changes.
- R2: The position is a 32-bit two's-complement value and is 0 after reset.
- R3: The electrical index is 0 after reset, always stays in 0..ELEC_CNT-1 (ELEC_CNT = 400), and moves by one with every count.
- R4: The electrical index wraps from 399 to 0 going forward and from 0 to 399 going backward.
- R5: A sample in which A and B both change gives no count, and it sets jump_error. jump_error stays set until reset.
- R6: A rising edge on the index line sets the electrical index to 0 and leaves the position alone. It takes priority over a count in the same cycle.
- R7: At a sample strobe where the magnitude of the position change since the previous strobe is at least THRESH (2), speed equals that change and speed_is_period is 0.
- R8: At a sample strobe where the magnitude is below THRESH, speed_is_period is 1. In that case speed is the number of clock cycles between the last two counted edges, negated when the last edge was a reverse one.
- R9: The edge-interval timer saturates at 2^TMR_W-1 when no edge arrives. While it is saturated, and before two edges have been seen, a slow-mode speed is 0.
- R10: speed_valid rises on the clock edge that takes the strobe. speed and speed_valid hold until speed_ready is seen high, and speed_valid falls after that handshake. A strobe while a result is pending replaces the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_z | input | 1 | Encoder index mark (asynchronous) |
| sample_tick | input | 1 | One-cycle mechanical-loop sample strobe |
| pos_count | output | 32 | Signed mechanical position in counts |
| elec_angle | output | 9 | Electrical angle index, 0..399 |
| speed | output | 32 | Signed speed: counts per sample or edge interval |
| speed_is_period | output | 1 | 1 when speed holds an edge interval |
| speed_valid | output | 1 | Speed result pending |
| speed_ready | input | 1 | Consumer accepts the pending result |
| jump_error | output | 1 | Sticky flag for an undecodable double change |

## Verification
The decoder is driven with runs of forward steps, runs of reverse steps that cross zero in both counters, a double-bit jump, and an index pulse. Together these separate direction decoding, both wrap points, the rejection of illegal jumps, and realignment of the index. Speed is tried four ways. Bursts of 10 and 6 steps, and a burst of exactly THRESH steps, check the difference path and its boundary. Single steps spaced a known number of cycles apart in either direction separate the interval path and its sign. A long idle gap shows timer saturation giving zero. Strobes while the consumer holds ready low show the hold and replace rules.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  // What the speed word currently carries
  typedef enum logic {
    SPD_DELTA  = 1'b0,
    SPD_PERIOD = 1'b1
  } spd_kind_e;
endpackage

// File: rtl/qenc_decode.sv
module qenc_decode #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_in,
  input  logic b_in,
  input  logic z_in,
  output logic step_up,
  output logic step_dn,
  output logic z_rise,
  output logic jump
);
  logic [SYNC_STAGES-1:0] a_sh, b_sh, z_sh;
  logic [1:0] prev_ab, cur_ab, chg;
  logic       z_d;
  logic [1:0] arm_cnt;
  logic       armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sh    <= '0;
      b_sh    <= '0;
      z_sh    <= '0;
      prev_ab <= 2'b00;
      z_d     <= 1'b0;
      arm_cnt <= 2'd0;
    end else begin
      a_sh    <= {a_sh[SYNC_STAGES-2:0], a_in};
      b_sh    <= {b_sh[SYNC_STAGES-2:0], b_in};
      z_sh    <= {z_sh[SYNC_STAGES-2:0], z_in};
      prev_ab <= cur_ab;
      z_d     <= z_sh[SYNC_STAGES-1];
      if (arm_cnt != 2'd3) arm_cnt <= arm_cnt + 2'd1;
    end
  end

  always_comb begin
    cur_ab  = {a_sh[SYNC_STAGES-1], b_sh[SYNC_STAGES-1]};
    chg     = cur_ab ^ prev_ab;
    armed   = (arm_cnt == 2'd3);
    // single-bit change: forward when new A differs from old B
    step_up = armed && (chg == 2'b01 || chg == 2'b10) && (cur_ab[1] ^ prev_ab[0]);
    step_dn = armed && (chg == 2'b01 || chg == 2'b10) && !(cur_ab[1] ^ prev_ab[0]);
    jump    = armed && (chg == 2'b11);
    z_rise  = armed && z_sh[SYNC_STAGES-1] && !z_d;
  end
endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
  parameter int POS_W    = 32,
  parameter int ELEC_CNT = 400,
  parameter int ELEC_W   = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_up,
  input  logic                    step_dn,
  input  logic                    z_rise,
  output logic signed [POS_W-1:0] pos,
  output logic [ELEC_W-1:0]       elec
);
  localparam logic [ELEC_W-1:0] ELEC_TOP = ELEC_W'(ELEC_CNT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      elec <= '0;
    end else begin
      if (step_up)      pos <= pos + 1'b1;
      else if (step_dn) pos <= pos - 1'b1;

      if (z_rise)       elec <= '0;
      else if (step_up) elec <= (elec == ELEC_TOP) ? '0 : elec + 1'b1;
      else if (step_dn) elec <= (elec == '0) ? ELEC_TOP : elec - 1'b1;
    end
  end

  p_up_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> pos == $past(pos) + 1);
  p_dn_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> pos == $past(pos) - 1);
  p_elec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    elec <= ELEC_TOP);
  p_wrap_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !z_rise && elec == ELEC_TOP) |=> elec == '0);
  p_wrap_bwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !z_rise && elec == '0) |=> elec == ELEC_TOP);
  p_index_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    z_rise |=> elec == '0);
endmodule

// File: rtl/qenc_speed.sv
module qenc_speed
  import qenc_pkg::*;
#(
  parameter int POS_W  = 32,
  parameter int TMR_W  = 16,
  parameter int THRESH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_up,
  input  logic                    step_dn,
  input  logic signed [POS_W-1:0] pos,
  input  logic                    tick,
  input  logic                    spd_ready,
  output logic signed [POS_W-1:0] spd,
  output spd_kind_e               spd_kind,
  output logic                    spd_valid
);
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  logic [TMR_W-1:0]        timer, per;
  logic                    per_ok, per_neg;
  logic signed [POS_W-1:0] pos_last, delta, per_val, slow_spd;
  logic [POS_W-1:0]        mag;
  logic                    fast;

  always_comb begin
    delta    = pos - pos_last;
    mag      = delta[POS_W-1] ? -delta : delta;
    fast     = mag >= POS_W'(THRESH);
    per_val  = $signed({{(POS_W-TMR_W){1'b0}}, per});
    slow_spd = (timer == TMR_MAX || !per_ok) ? '0 : (per_neg ? -per_val : per_val);
  end

  // edge-interval timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer   <= TMR_MAX;
      per     <= '0;
      per_ok  <= 1'b0;
      per_neg <= 1'b0;
    end else if (step_up || step_dn) begin
      timer   <= '0;
      per     <= (timer == TMR_MAX) ? TMR_MAX : timer + 1'b1;
      per_ok  <= (timer != TMR_MAX);
      per_neg <= step_dn;
    end else if (timer != TMR_MAX) begin
      timer <= timer + 1'b1;
    end
  end

  // sample and output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_last  <= '0;
      spd       <= '0;
      spd_kind  <= SPD_DELTA;
      spd_valid <= 1'b0;
    end else if (tick) begin
      pos_last  <= pos;
      spd       <= fast ? delta : slow_spd;
      spd_kind  <= fast ? SPD_DELTA : SPD_PERIOD;
      spd_valid <= 1'b1;
    end else if (spd_valid && spd_ready) begin
      spd_valid <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_valid && !spd_ready && !tick) |=> spd_valid && $stable(spd));
  p_tick_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> spd_valid);
  p_sat_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fast && timer == TMR_MAX) |=> spd == '0);
endmodule

// File: rtl/qenc_pos_speed.sv
module qenc_pos_speed
  import qenc_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int ELEC_CNT    = 400,
  parameter int TMR_W       = 16,
  parameter int THRESH      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ELEC_W     = $clog2(ELEC_CNT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enc_a,
  input  logic                    enc_b,
  input  logic                    enc_z,
  input  logic                    sample_tick,
  output logic signed [POS_W-1:0] pos_count,
  output logic [ELEC_W-1:0]       elec_angle,
  output logic signed [POS_W-1:0] speed,
  output logic                    speed_is_period,
  output logic                    speed_valid,
  input  logic                    speed_ready,
  output logic                    jump_error
);
  logic      step_up, step_dn, z_rise, jump;
  spd_kind_e kind;

  qenc_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst_n(rst_n), .a_in(enc_a), .b_in(enc_b), .z_in(enc_z),
    .step_up(step_up), .step_dn(step_dn), .z_rise(z_rise), .jump(jump)
  );

  qenc_count #(.POS_W(POS_W), .ELEC_CNT(ELEC_CNT), .ELEC_W(ELEC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .z_rise(z_rise), .pos(pos_count), .elec(elec_angle)
  );

  qenc_speed #(.POS_W(POS_W), .TMR_W(TMR_W), .THRESH(THRESH)) u_spd (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .pos(pos_count), .tick(sample_tick), .spd_ready(speed_ready),
    .spd(speed), .spd_kind(kind), .spd_valid(speed_valid)
  );

  assign speed_is_period = (kind == SPD_PERIOD);

  always_ff @(posedge clk) begin
    if (!rst_n)    jump_error <= 1'b0;
    else if (jump) jump_error <= 1'b1;
  end

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jump_error |=> jump_error);
  p_jump_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> pos_count == $past(pos_count));
endmodule

// File: tb/qenc_pos_speed_test.sv
module qenc_pos_speed_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
  logic sample_tick = 1'b0, speed_ready = 1'b0;
  logic signed [31:0] pos_count, speed;
  logic [8:0] elec_angle;
  logic speed_is_period, speed_valid, jump_error;

  int n_cmp = 0, n_bad = 0;
  int phase = 0;
  longint exp_pos = 0;
  int exp_elec = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qenc_pos_speed #(.TMR_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .sample_tick(sample_tick), .pos_count(pos_count), .elec_angle(elec_angle),
    .speed(speed), .speed_is_period(speed_is_period), .speed_valid(speed_valid),
    .speed_ready(speed_ready), .jump_error(jump_error)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one gray step on the next falling edge
  task automatic step(input bit fwd);
    @(negedge clk);
    phase = fwd ? (phase + 1) % 4 : (phase + 3) % 4;
    case (phase)
      0: {enc_a, enc_b} = 2'b00;
      1: {enc_a, enc_b} = 2'b10;
      2: {enc_a, enc_b} = 2'b11;
      default: {enc_a, enc_b} = 2'b01;
    endcase
    exp_pos  = fwd ? exp_pos + 1 : exp_pos - 1;
    exp_elec = fwd ? (exp_elec + 1) % 400 : (exp_elec + 399) % 400;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
  endtask

  task automatic check_counters(input string tag);
    check($signed(pos_count) == exp_pos, {tag, " pos"}, $signed(pos_count), exp_pos);
    check(int'(elec_angle) == exp_elec, {tag, " elec"}, elec_angle, exp_elec);
  endtask

  task automatic check_speed(input longint exp, input bit per, input string tag);
    check(speed_valid == 1'b1, {tag, " valid"}, speed_valid, 1);
    check($signed(speed) == exp, {tag, " speed"}, $signed(speed), exp);
    check(speed_is_period == per, {tag, " kind"}, speed_is_period, per);
    @(negedge clk) speed_ready = 1'b1;
    @(negedge clk) speed_ready = 1'b0;
    check(speed_valid == 1'b0, "R10 consumed", speed_valid, 0);
  endtask

  task automatic t_reset();
    check_counters("R2 R3 reset");
    check(speed_valid == 1'b0, "R10 reset valid", speed_valid, 0);
    check(jump_error == 1'b0, "R5 reset err", jump_error, 0);
  endtask

  task automatic t_forward();
    for (int i = 0; i < 10; i++) step(1);
    idle(5);
    check_counters("R1 forward");
  endtask

  task automatic t_reverse_wrap();
    for (int i = 0; i < 15; i++) step(0);
    idle(5);
    check_counters("R4 R2 reverse through zero");
    check(elec_angle == 9'd395, "R4 elec 395", elec_angle, 395);
  endtask

  task automatic t_forward_wrap();
    for (int i = 0; i < 5; i++) step(1);
    idle(5);
    check(elec_angle == 9'd0, "R4 399 to 0", elec_angle, 0);
    step(1);
    idle(5);
    check_counters("R3 after wrap");
  endtask

  task automatic t_index();
    for (int i = 0; i < 7; i++) step(1);
    @(negedge clk) enc_z = 1'b1;
    idle(3);
    enc_z = 1'b0;
    exp_elec = 0;
    idle(5);
    check_counters("R6 index");
    step(0);
    idle(5);
    check(elec_angle == 9'd399, "R4 R6 back from index", elec_angle, 399);
  endtask

  task automatic t_jump();
    @(negedge clk) {enc_a, enc_b} = ~{enc_a, enc_b};
    phase = (phase + 2) % 4;
    idle(5);
    check_counters("R5 jump ignored");
    check(jump_error == 1'b1, "R5 error set", jump_error, 1);
    step(1);
    idle(5);
    check_counters("R5 counting resumes");
    check(jump_error == 1'b1, "R5 sticky", jump_error, 1);
  endtask

  task automatic t_delta();
    tick();
    @(negedge clk) speed_ready = 1'b1;
    @(negedge clk) speed_ready = 1'b0;
    for (int i = 0; i < 10; i++) step(1);
    idle(5);
    tick();
    check_speed(10, 1'b0, "R7 burst fwd");
    for (int i = 0; i < 6; i++) step(0);
    idle(5);
    tick();
    check_speed(-6, 1'b0, "R7 burst rev");
    step(1); step(1);
    idle(5);
    tick();
    check_speed(2, 1'b0, "R7 threshold");
  endtask

  task automatic t_period(input bit fwd, input int p);
    step(fwd);
    idle(19);
    tick();
    @(negedge clk) speed_ready = 1'b1;
    @(negedge clk) speed_ready = 1'b0;
    idle(p - 24);
    step(fwd);
    idle(6);
    tick();
    check_speed(fwd ? p : -p, 1'b1, "R8 interval");
  endtask

  task automatic t_saturate();
    idle(1100);
    tick();
    check_speed(0, 1'b1, "R9 saturated");
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 3; i++) step(1);
    idle(5);
    tick();
    for (int i = 0; i < 4; i++) step(1);
    idle(5);
    check(speed_valid == 1'b1, "R10 held valid", speed_valid, 1);
    check($signed(speed) == 3, "R10 held value", $signed(speed), 3);
    tick();
    check_speed(4, 1'b0, "R10 replaced");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(10);
    t_reset();
    t_forward();
    t_reverse_wrap();
    t_forward_wrap();
    t_index();
    t_jump();
    t_delta();
    t_period(1'b1, 60);
    t_period(1'b0, 45);
    t_saturate();
    t_backpressure();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule